// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that a processor controls only by writing 16-bit key words into one register. A key starts the timer. Another key restarts the countdown, which is the periodic "feed". A third key opens the divider and reload registers for writing, and a fourth key closes them again. Once the timer runs, software cannot stop it. If the countdown is not fed in time, the block issues a single-cycle reset request to the system.

The timer is a 12-bit down-counter. It decrements once per divider period of a slow timebase. The slow timebase is modelled as a one-cycle enable pulse, `lsi_en`, in the bus clock domain. New divider and reload values pass through a modelled clock-domain delay before the counter uses them. During that delay a status bit per register reports the update as pending. The bus uses word addresses: index 0 is the key register, 1 the divider, 2 the reload value and 3 the status. Every other index reads zero.

Top module: `kwdt_top`

## Requirements
- R1: After reset the timer is stopped and the configuration registers are locked. The divider reads 0, the reload reads 0xFFF, the status reads 0 and `rst_req` is low.
- R2: The key register (index 0) compares all 16 bits of a written word against the four keys and always reads zero.
- R3: Writing key 0x5555 opens the divider and reload registers for writing. Key 0x0000, or any word that is not one of the four keys, closes them. A write to index 1 or 2 while they are closed changes neither the stored value nor the status.
- R4: The divider field is bits 2:0 of index 1 and the reload field is bits 11:0 of index 2. These registers read back the last accepted value. Bits above the fields, and indexes 4 to 7, read zero.
- R5: Status bit 0 (divider) or bit 1 (reload) goes high in the cycle after an accepted write to that register. It falls at the fifth `lsi_en` pulse that follows. A further write restarts the delay.
- R6: The counter keeps using the old divider and reload values until the matching status bit has cleared.
- R7: Key 0xCCCC starts a stopped timer and loads the counter from the active reload value. Before this key arrives, `rst_req` never rises, whatever `lsi_en` does.
- R8: With reload value R and divide ratio D, `rst_req` pulses high for exactly one cycle after (R+1)·D `lsi_en` pulses, counted from the last start or feed. The counter then reloads and the next period begins by itself.
- R9: Divider code n selects a ratio of 4·2^n for n = 0 to 6; code 7 also gives 256.
- R10: Key 0xAAAA reloads the counter and restarts the divider phase, so a full period begins again.
- R11: Once started, no key and no other bus write stops the timer; only reset does.
- R12: While `lsi_en` is low, the counter, the divider phase and the pending-update delays all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lsi_en | input | 1 | One-cycle pulse per slow-timebase tick |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Word index of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The hardest case to reach is the window in which a new reload value has been written but is still pending. A feed in that window must load the old value, and only the next automatic reload may pick up the new one. The bench writes the reload register and issues the feed key in the very next cycle, which is well inside the five-pulse delay. It then measures two consecutive expiry periods and expects the first with the old value and the second with the new one. A related case holds `lsi_en` low across a write: the status bit must stay set for as long as the pulses are withheld, and the counter must stay frozen.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [15:0] KEY_START = 16'hCCCC;
  localparam logic [15:0] KEY_FEED  = 16'hAAAA;
  localparam logic [15:0] KEY_OPEN  = 16'h5555;
  localparam logic [15:0] KEY_SHUT  = 16'h0000;

  typedef enum logic [2:0] {
    IDX_KEY  = 3'd0,
    IDX_DIV  = 3'd1,
    IDX_RLD  = 3'd2,
    IDX_STAT = 3'd3
  } reg_idx_e;
endpackage

// File: rtl/kwdt_keyctl.sv
module kwdt_keyctl #(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  output logic             unlocked,
  output logic             running,
  output logic             load_req
);
  import kwdt_pkg::*;

  logic unlock_q, unlock_d;
  logic run_q, run_d;

  always_comb begin
    unlock_d = unlock_q;
    run_d    = run_q;
    load_req = 1'b0;
    if (key_wr) begin
      if (key_val == KEY_START) begin
        run_d    = 1'b1;
        load_req = !run_q;
      end else if (key_val == KEY_FEED) begin
        load_req = 1'b1;
      end else if (key_val == KEY_OPEN) begin
        unlock_d = 1'b1;
      end else begin
        unlock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      unlock_q <= unlock_d;
      run_q    <= run_d;
    end
  end

  assign unlocked = unlock_q;
  assign running  = run_q;
endmodule

// File: rtl/kwdt_shadow.sv
module kwdt_shadow #(
  parameter int         W        = 12,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int         SYNC_LEN = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lsi_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int SC_W = $clog2(SYNC_LEN + 1);

  logic [W-1:0]    shd_q, shd_d, act_q, act_d;
  logic            busy_q, busy_d;
  logic [SC_W-1:0] sc_q, sc_d;

  always_comb begin
    shd_d  = shd_q;
    act_d  = act_q;
    busy_d = busy_q;
    sc_d   = sc_q;
    if (wr) begin
      shd_d  = wdata;
      busy_d = 1'b1;
      sc_d   = '0;
    end else if (busy_q && lsi_en) begin
      if (sc_q == SC_W'(SYNC_LEN - 1)) begin
        busy_d = 1'b0;
        act_d  = shd_q;
        sc_d   = '0;
      end else begin
        sc_d = sc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= RST_VAL;
      act_q  <= RST_VAL;
      busy_q <= 1'b0;
      sc_q   <= '0;
    end else begin
      shd_q  <= shd_d;
      act_q  <= act_d;
      busy_q <= busy_d;
      sc_q   <= sc_d;
    end
  end

  assign shadow = shd_q;
  assign active = act_q;
  assign busy   = busy_q;
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int CNT_W     = 12,
  parameter int DIV_W     = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lsi_en,
  input  logic             running,
  input  logic             load,
  input  logic [DIV_W-1:0] div_code,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req
);
  localparam int PCNT_W = MAX_SHIFT + 2;

  logic [PCNT_W-1:0] pc_q, pc_d, div_last;
  logic [PCNT_W:0]   span;
  logic [DIV_W-1:0]  sh;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              req_q, req_d;
  logic              tick;

  always_comb begin
    sh       = (div_code > DIV_W'(MAX_SHIFT)) ? DIV_W'(MAX_SHIFT) : div_code;
    span     = (PCNT_W + 1)'(4) << sh;
    div_last = PCNT_W'(span - 1'b1);
    tick     = running && lsi_en && (pc_q >= div_last);
  end

  always_comb begin
    pc_d  = pc_q;
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (load) begin
      pc_d  = '0;
      cnt_d = reload;
    end else if (tick) begin
      pc_d = '0;
      if (cnt_q == '0) begin
        cnt_d = reload;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (running && lsi_en) begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '1;
      req_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = req_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 12,
  parameter int DIV_W     = 3,
  parameter int MAX_SHIFT = 6,
  parameter int SYNC_LEN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lsi_en,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  import kwdt_pkg::*;

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic             unlocked, running, load_req;
  logic             key_wr, div_wr, rld_wr;
  logic [DIV_W-1:0] div_shadow, div_active;
  logic [CNT_W-1:0] rld_shadow, rld_active, cnt_val;
  logic             busy_div, busy_rld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign key_wr = bus_wr && (bus_addr == IDX_W'(IDX_KEY));
  assign div_wr = bus_wr && unlocked && (bus_addr == IDX_W'(IDX_DIV));
  assign rld_wr = bus_wr && unlocked && (bus_addr == IDX_W'(IDX_RLD));

  kwdt_keyctl #(.KEY_W(DATA_W)) u_keyctl (
    .clk(clk), .rst_n(rst_sync_n), .key_wr(key_wr), .key_val(bus_wdata),
    .unlocked(unlocked), .running(running), .load_req(load_req)
  );

  kwdt_shadow #(.W(DIV_W), .RST_VAL('0), .SYNC_LEN(SYNC_LEN)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .lsi_en(lsi_en), .wr(div_wr),
    .wdata(bus_wdata[DIV_W-1:0]), .shadow(div_shadow), .active(div_active),
    .busy(busy_div)
  );

  kwdt_shadow #(.W(CNT_W), .RST_VAL('1), .SYNC_LEN(SYNC_LEN)) u_rld (
    .clk(clk), .rst_n(rst_sync_n), .lsi_en(lsi_en), .wr(rld_wr),
    .wdata(bus_wdata[CNT_W-1:0]), .shadow(rld_shadow), .active(rld_active),
    .busy(busy_rld)
  );

  kwdt_count #(.CNT_W(CNT_W), .DIV_W(DIV_W), .MAX_SHIFT(MAX_SHIFT)) u_count (
    .clk(clk), .rst_n(rst_sync_n), .lsi_en(lsi_en), .running(running),
    .load(load_req), .div_code(div_active), .reload(rld_active),
    .cnt(cnt_val), .rst_req(rst_req)
  );

  always_comb begin
    case (bus_addr)
      IDX_W'(IDX_DIV):  bus_rdata = DATA_W'(div_shadow);
      IDX_W'(IDX_RLD):  bus_rdata = DATA_W'(rld_shadow);
      IDX_W'(IDX_STAT): bus_rdata = DATA_W'({busy_rld, busy_div});
      default:          bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lsi_en,
  input logic              running,
  input logic              rst_req,
  input logic              load,
  input logic [1:0]        busy,
  input logic [CNT_W-1:0]  cnt,
  input logic [IDX_W-1:0]  bus_addr,
  input logic [DATA_W-1:0] bus_rdata
);
  // R11
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(running));

  // R8
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R7
  req_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> running);

  // R5
  div_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[0]) |-> $past(lsi_en));

  // R5
  rld_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[1]) |-> $past(lsi_en));

  // R12
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(lsi_en) && !$past(load)) |-> $stable(cnt));

  // R2
  key_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (bus_rdata == '0));
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .lsi_en(lsi_en), .running(running),
  .rst_req(rst_req), .load(load_req), .busy({busy_rld, busy_div}),
  .cnt(cnt_val), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;
  logic        clk, rst_n, lsi_en, bus_wr, rst_req;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  int n_chk = 0;
  int n_bad = 0;

  kwdt_top u_kwdt_top (
    .clk(clk), .rst_n(rst_n), .lsi_en(lsi_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
    bus_addr = 3'd0;
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      n++;
      if (rst_req) break;
    end
  endtask

  task automatic set_lsi(input logic v);
    @(negedge clk); lsi_en = v;
  endtask

  task automatic configure(input logic [2:0] code, input logic [11:0] r);
    wr(3'd0, 16'h5555);
    wr(3'd1, {13'd0, code});
    wr(3'd2, {4'd0, r});
    repeat (8) @(posedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(3'd1, d); check("R1 div", d, 0);
    rd(3'd2, d); check("R1 reload", d, 16'h0FFF);
    rd(3'd3, d); check("R1 status", d, 0);
    check("R1 rst_req", rst_req, 0);
    wr(3'd1, 16'h0005);
    rd(3'd1, d); check("R3 locked div write", d, 0);
    rd(3'd3, d); check("R3 locked no busy", d, 0);
  endtask

  task automatic t_lock;
    logic [15:0] d;
    wr(3'd0, 16'h5555);
    wr(3'd0, 16'h1234);
    wr(3'd2, 16'h0077);
    rd(3'd2, d); check("R3 undefined key relocks", d, 16'h0FFF);
    wr(3'd0, 16'hF555);
    wr(3'd2, 16'h0077);
    rd(3'd2, d); check("R2 partial key ignored", d, 16'h0FFF);
    wr(3'd0, 16'h5555);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0003);
    rd(3'd1, d); check("R3 shut key relocks", d, 0);
    rd(3'd0, d); check("R2 key reads zero", d, 0);
  endtask

  task automatic t_fields_busy;
    logic [15:0] d;
    set_lsi(1'b0);
    wr(3'd0, 16'h5555);
    wr(3'd2, 16'hF123);
    rd(3'd2, d); check("R4 reload field", d, 16'h0123);
    wr(3'd1, 16'hFFFF);
    rd(3'd1, d); check("R4 div field", d, 16'h0007);
    rd(3'd5, d); check("R4 unused index", d, 0);
    repeat (20) @(posedge clk);
    rd(3'd3, d); check("R12 busy held without pulses", d, 16'h0003);
    set_lsi(1'b1);
    @(posedge clk); #1;
    repeat (3) @(posedge clk);
    #1; check("R5 busy after four pulses", bus_rdata_stat(), 16'h0003);
    @(posedge clk); #1;
    check("R5 busy clear after fifth", bus_rdata_stat(), 0);
  endtask

  function automatic logic [15:0] bus_rdata_stat();
    return {14'd0, u_kwdt_top.busy_rld, u_kwdt_top.busy_div};
  endfunction

  task automatic t_start;
    int n;
    configure(3'd0, 12'd3);
    n = 0;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      if (rst_req) n++;
    end
    check("R7 no request before start", n, 0);
    wr(3'd0, 16'hCCCC);
    measure(n); check("R8 period 4x4", n, 16);
    @(posedge clk); #1; check("R8 one-cycle pulse", rst_req, 0);
    measure(n); check("R8 automatic next period", n, 15);
  endtask

  task automatic t_ratios;
    int n;
    configure(3'd1, 12'd3); wr(3'd0, 16'hAAAA);
    measure(n); check("R9 code1", n, 32);
    configure(3'd2, 12'd7); wr(3'd0, 16'hAAAA);
    measure(n); check("R9 code2", n, 128);
    configure(3'd6, 12'd0); wr(3'd0, 16'hAAAA);
    measure(n); check("R9 code6", n, 256);
    configure(3'd7, 12'd1); wr(3'd0, 16'hAAAA);
    measure(n); check("R9 code7", n, 512);
  endtask

  task automatic t_feed_stop;
    int n;
    configure(3'd0, 12'd7);
    wr(3'd0, 16'hAAAA);
    repeat (20) @(posedge clk);
    wr(3'd0, 16'hAAAA);
    measure(n); check("R10 feed restarts", n, 32);
    wr(3'd0, 16'hAAAA);
    wr(3'd0, 16'h1234);
    wr(3'd0, 16'h0000);
    measure(n); check("R11 keys do not stop", n + 2, 32);
  endtask

  task automatic t_pending;
    int n;
    configure(3'd0, 12'd3);
    wr(3'd0, 16'h5555);
    wr(3'd2, 16'd9);
    wr(3'd0, 16'hAAAA);
    measure(n); check("R6 old reload while pending", n, 16);
    measure(n); check("R6 new reload after update", n, 40);
  endtask

  task automatic t_freeze;
    int n;
    int seen;
    wr(3'd0, 16'hAAAA);
    set_lsi(1'b0);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1;
      if (rst_req) seen++;
    end
    check("R12 frozen without pulses", seen, 0);
    set_lsi(1'b1);
    measure(n); check("R12 full period after freeze", n, 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lsi_en = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset;
    t_lock;
    t_fields_busy;
    t_start;
    t_ratios;
    t_feed_stop;
    t_pending;
    t_freeze;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule